// File: doc/BRIEF.md
# SDRAM Bank State Tracker

This block sits on the memory side of a four-bank synchronous DRAM command bus and follows what the device itself would do with each command. On every rising clock edge it samples the clock-enable, chip-select, the three command strobes, the two bank-select bits and the row/column address. From these it keeps an open/idle flag and the latched row for each bank, and it reports illegal commands as a one-cycle error strobe.

Reads and writes that ask for automatic precharge close their bank a fixed number of edges after the command. An explicit precharge closes one bank or all banks at once, and it cancels any pending automatic close. While clock-enable is low the command bus is ignored, and the block reports one of two power-down codes. The code depends on whether any row is open at that edge. There is no storage array, no data path and no mode register in this block.

Top module: `sdram_bank_tracker`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) leaves every bank idle, every latched row at zero, the power code at 0 (normal) and the error strobe low.
- R2: At an edge where cs_n is high, the command strobes are ignored: no bank or row changes, and the error strobe stays low.
- R3: The command code is {cs_n,ras_n,cas_n,we_n}, with activate = 0011. An activate to an idle bank, chosen by ba (ba = i selects bank i), opens that bank and latches addr[11:0] as its row.
- R4: A read (0101) or a write (0100) addressed to an idle bank raises err_pulse for exactly the cycle after that edge. It changes no bank state and schedules no precharge, even when addr[10] is high.
- R5: An activate to a bank that is already open raises err_pulse for one cycle and leaves the bank's flag and row unchanged.
- R6: Precharge (0010) with addr[10] low closes only bank ba. With addr[10] high it closes all banks. A precharge also cancels an automatic close that is pending on the banks it closes.
- R7: A read or write to an open bank with addr[10] high closes that bank at the AP_DELAY-th edge after the command edge (4 by default). With addr[10] low the bank stays open.
- R8: At an edge where cke is low, the power code becomes 1 (precharge power-down) if every bank is idle, or 2 (active power-down) if any bank is open. Commands at that edge are ignored.
- R9: At the first edge where cke is high again, the power code returns to 0, and the command at that same edge is decoded normally.
- R10: The other codes leave bank state untouched and raise no error. These are refresh (0001), mode set (0000), burst stop (0110) and no-operation (0111).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; low selects power-down |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address; bit 10 is the precharge qualifier |
| bank_open | output | 4 | Bit i high when bank i holds an open row |
| bank_row | output | 48 | Latched rows, bank i in bits [12*i+11:12*i] |
| pwr_state | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down |
| err_pulse | output | 1 | One-cycle strobe for an illegal access |

## Verification
The command stream is exercised in several arrangements. Legal activates on different banks check that bank selection is decoded correctly. Reads and writes to idle banks and repeated activates check that the error strobe fires without any change of state. Deselected cycles carrying an activate code show that chip select gates the whole command. Automatic precharge is tried both left to expire and cut short by an explicit precharge, which separates countdown timing from cancellation. Power-down is entered with and without open rows, and a precharge is issued on the very edge that clock-enable returns. Together these tell the two power codes apart and show that decoding resumes at once.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF,
      CMD_MODE,
      CMD_STOP
   } cmd_t;

   localparam logic [1:0] PWR_NORMAL = 2'd0;
   localparam logic [1:0] PWR_PRE_PD = 2'd1;
   localparam logic [1:0] PWR_ACT_PD = 2'd2;

endpackage

// File: rtl/sbt_cmd_decode.sv
module sbt_cmd_decode
   import sbt_pkg::*;
(
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_t cmd
);

   always_comb begin
      cmd = CMD_NOP;
      if (cke && !cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = CMD_MODE;
            3'b110:  cmd = CMD_STOP;
            default: cmd = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sbt_bank.sv
module sbt_bank #(
   parameter int ROW_W    = 12,
   parameter int AP_DELAY = 4,
   localparam int CNT_W   = $clog2(AP_DELAY + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             act_hit,
   input  logic             rw_hit,
   input  logic             ap_req,
   input  logic             pre_hit,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q,
   output logic             bad_cmd
);

   logic [CNT_W-1:0] ap_cnt;
   logic             act_ok;
   logic             ap_ok;

   assign act_ok  = act_hit && !is_open;
   assign ap_ok   = rw_hit && is_open && ap_req;
   assign bad_cmd = (act_hit && is_open) || (rw_hit && !is_open);

   always_ff @(posedge clk) begin
      if (rst) begin
         is_open <= 1'b0;
         row_q   <= '0;
         ap_cnt  <= '0;
      end else if (pre_hit) begin
         is_open <= 1'b0;
         ap_cnt  <= '0;
      end else begin
         if (act_ok) begin
            is_open <= 1'b1;
            row_q   <= row_in;
         end
         if (ap_ok) begin
            ap_cnt <= CNT_W'(AP_DELAY);
         end else if (ap_cnt != '0) begin
            ap_cnt <= ap_cnt - 1'b1;
            if (ap_cnt == CNT_W'(1)) is_open <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sbt_power.sv
module sbt_power
   import sbt_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       cke,
   input  logic       any_open,
   output logic [1:0] pwr_state
);

   always_ff @(posedge clk) begin
      if (rst)       pwr_state <= PWR_NORMAL;
      else if (!cke) pwr_state <= any_open ? PWR_ACT_PD : PWR_PRE_PD;
      else           pwr_state <= PWR_NORMAL;
   end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
   import sbt_pkg::*;
#(
   parameter int BA_W     = 2,
   parameter int ROW_W    = 12,
   parameter int AP_BIT   = 10,
   parameter int AP_DELAY = 4,
   localparam int NUM_BANKS = 1 << BA_W
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       cke,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BA_W-1:0]            ba,
   input  logic [ROW_W-1:0]           addr,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] bank_row,
   output logic [1:0]                 pwr_state,
   output logic                       err_pulse
);

   if (AP_BIT >= ROW_W) begin : g_bad_ap_bit
      $error("AP_BIT must index a bit inside the address");
   end
   if (AP_DELAY < 1) begin : g_bad_delay
      $error("AP_DELAY must be at least one edge");
   end
   if (BA_W < 1) begin : g_bad_ba
      $error("BA_W must be at least one bit");
   end

   cmd_t                 cmd;
   logic [NUM_BANKS-1:0] bad_vec;
   logic                 pre_all;
   logic                 is_rw;

   sbt_cmd_decode u_dec (
      .cke   (cke),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (cmd)
   );

   assign is_rw   = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign pre_all = (cmd == CMD_PRE) && addr[AP_BIT];

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic sel;
      assign sel = (ba == BA_W'(i));

      sbt_bank #(
         .ROW_W    (ROW_W),
         .AP_DELAY (AP_DELAY)
      ) u_bank (
         .clk     (clk),
         .rst     (rst),
         .act_hit (sel && cmd == CMD_ACT),
         .rw_hit  (sel && is_rw),
         .ap_req  (addr[AP_BIT]),
         .pre_hit (pre_all || (sel && cmd == CMD_PRE)),
         .row_in  (addr),
         .is_open (bank_open[i]),
         .row_q   (bank_row[i*ROW_W +: ROW_W]),
         .bad_cmd (bad_vec[i])
      );
   end

   sbt_power u_pwr (
      .clk       (clk),
      .rst       (rst),
      .cke       (cke),
      .any_open  (|bank_open),
      .pwr_state (pwr_state)
   );

   always_ff @(posedge clk) begin
      if (rst) err_pulse <= 1'b0;
      else     err_pulse <= |bad_vec;
   end

endmodule

// File: rtl/sbt_checker.sv
module sbt_checker
   import sbt_pkg::*;
#(
   parameter int BA_W     = 2,
   parameter int ROW_W    = 12,
   parameter int AP_BIT   = 10,
   parameter int NUM_BANKS = 4
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       cke,
   input logic                       cs_n,
   input logic                       ras_n,
   input logic                       cas_n,
   input logic                       we_n,
   input logic [BA_W-1:0]            ba,
   input logic [ROW_W-1:0]           addr,
   input logic [NUM_BANKS-1:0]       bank_open,
   input logic [NUM_BANKS*ROW_W-1:0] bank_row,
   input logic [1:0]                 pwr_state,
   input logic                       err_pulse
);

   logic live, is_act, is_rw, is_pre;
   assign live   = cke && !cs_n;
   assign is_act = live && {ras_n, cas_n, we_n} == 3'b011;
   assign is_rw  = live && !ras_n == 1'b0 && cas_n == 1'b0 && ras_n;
   assign is_pre = live && {ras_n, cas_n, we_n} == 3'b010;

   // R1: reset leaves everything idle
   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> (bank_open == '0 && pwr_state == PWR_NORMAL && !err_pulse));

   // R2: deselected edge changes no row and raises no error
   p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (rst)
      (cs_n && cke) |=> ($stable(bank_row) && !err_pulse));

   // R3: legal activate opens the bank with the sampled row
   p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
      (is_act && !bank_open[ba]) |=>
         (bank_open[$past(ba)] && bank_row[$past(ba)*ROW_W +: ROW_W] == $past(addr)));

   // R4: access to an idle bank strobes the error
   p_idle_access_r4: assert property (@(posedge clk) disable iff (rst)
      (is_rw && !bank_open[ba]) |=> err_pulse);

   // R5: activate to an open bank strobes the error
   p_double_act_r5: assert property (@(posedge clk) disable iff (rst)
      (is_act && bank_open[ba]) |=> err_pulse);

   // R6: precharge-all empties every bank
   p_pre_all_r6: assert property (@(posedge clk) disable iff (rst)
      (is_pre && addr[AP_BIT]) |=> (bank_open == '0));

   // R8: power-down code follows open state
   p_pd_class_r8: assert property (@(posedge clk) disable iff (rst)
      (!cke) |=> (pwr_state == ($past(bank_open) != '0 ? PWR_ACT_PD : PWR_PRE_PD)
                  && !err_pulse));

   // R9: clock enable high returns to normal
   p_wake_r9: assert property (@(posedge clk) disable iff (rst)
      cke |=> (pwr_state == PWR_NORMAL));

endmodule

bind sdram_bank_tracker sbt_checker #(
   .BA_W      (BA_W),
   .ROW_W     (ROW_W),
   .AP_BIT    (AP_BIT),
   .NUM_BANKS (NUM_BANKS)
) u_chk (.*);

// File: tb/tb_sdram_bank_tracker.sv
module tb_sdram_bank_tracker;

   localparam int CLK_PERIOD = 10;
   localparam int ROW_W = 12;
   localparam int NV = 29;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cke = 1'b1;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic [3:0]  bank_open;
   logic [47:0] bank_row;
   logic [1:0]  pwr_state;
   logic        err_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_bank_tracker dut (
      .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
      .bank_open(bank_open), .bank_row(bank_row),
      .pwr_state(pwr_state), .err_pulse(err_pulse)
   );

   // fields: [29:26] req, [25] cke, [24:21] cmd, [20:19] ba, [18:7] addr,
   //         [6:3] expected open, [2] expected err, [1:0] expected power
   localparam logic [29:0] VEC [NV] = '{
      {4'd10, 1'b1, 4'b0111, 2'd0, 12'h000, 4'b0000, 1'b0, 2'd0}, // R10 nop
      {4'd4,  1'b1, 4'b0101, 2'd0, 12'h000, 4'b0000, 1'b1, 2'd0}, // R4 read idle
      {4'd4,  1'b1, 4'b0100, 2'd2, 12'h400, 4'b0000, 1'b1, 2'd0}, // R4 write idle, ap
      {4'd3,  1'b1, 4'b0011, 2'd1, 12'h123, 4'b0010, 1'b0, 2'd0}, // R3 act b1
      {4'd5,  1'b1, 4'b0011, 2'd1, 12'h456, 4'b0010, 1'b1, 2'd0}, // R5 act twice
      {4'd2,  1'b1, 4'b1011, 2'd0, 12'h000, 4'b0010, 1'b0, 2'd0}, // R2 deselect
      {4'd3,  1'b1, 4'b0011, 2'd3, 12'h0F0, 4'b1010, 1'b0, 2'd0}, // R3 act b3
      {4'd7,  1'b1, 4'b0101, 2'd1, 12'h000, 4'b1010, 1'b0, 2'd0}, // R7 read no ap
      {4'd8,  1'b0, 4'b0111, 2'd0, 12'h000, 4'b1010, 1'b0, 2'd2}, // R8 active pd
      {4'd8,  1'b0, 4'b0011, 2'd0, 12'h000, 4'b1010, 1'b0, 2'd2}, // R8 act ignored
      {4'd9,  1'b1, 4'b0111, 2'd0, 12'h000, 4'b1010, 1'b0, 2'd0}, // R9 wake
      {4'd6,  1'b1, 4'b0010, 2'd3, 12'h000, 4'b0010, 1'b0, 2'd0}, // R6 pre one
      {4'd8,  1'b0, 4'b0111, 2'd0, 12'h000, 4'b0010, 1'b0, 2'd2}, // R8
      {4'd9,  1'b1, 4'b0010, 2'd1, 12'h000, 4'b0000, 1'b0, 2'd0}, // R9 pre on wake
      {4'd8,  1'b0, 4'b0111, 2'd0, 12'h000, 4'b0000, 1'b0, 2'd1}, // R8 precharge pd
      {4'd9,  1'b1, 4'b0011, 2'd0, 12'h010, 4'b0001, 1'b0, 2'd0}, // R9 act on wake
      {4'd3,  1'b1, 4'b0011, 2'd2, 12'h020, 4'b0101, 1'b0, 2'd0}, // R3 act b2
      {4'd7,  1'b1, 4'b0100, 2'd0, 12'h400, 4'b0101, 1'b0, 2'd0}, // R7 write ap k
      {4'd7,  1'b1, 4'b0111, 2'd0, 12'h000, 4'b0101, 1'b0, 2'd0}, // R7 k+1
      {4'd10, 1'b1, 4'b0110, 2'd0, 12'h000, 4'b0101, 1'b0, 2'd0}, // R10 burst stop k+2
      {4'd10, 1'b1, 4'b0001, 2'd0, 12'h000, 4'b0101, 1'b0, 2'd0}, // R10 refresh k+3
      {4'd7,  1'b1, 4'b0111, 2'd0, 12'h000, 4'b0100, 1'b0, 2'd0}, // R7 close at k+4
      {4'd7,  1'b1, 4'b0101, 2'd2, 12'h400, 4'b0100, 1'b0, 2'd0}, // R7 read ap k
      {4'd6,  1'b1, 4'b0010, 2'd2, 12'h000, 4'b0000, 1'b0, 2'd0}, // R6 pre cancels
      {4'd6,  1'b1, 4'b0011, 2'd2, 12'h030, 4'b0100, 1'b0, 2'd0}, // R6 reopen k+2
      {4'd6,  1'b1, 4'b0111, 2'd0, 12'h000, 4'b0100, 1'b0, 2'd0}, // R6 k+3
      {4'd6,  1'b1, 4'b0000, 2'd0, 12'h000, 4'b0100, 1'b0, 2'd0}, // R6 k+4 stays, R10 mode
      {4'd3,  1'b1, 4'b0011, 2'd0, 12'h040, 4'b0101, 1'b0, 2'd0}, // R3 act b0
      {4'd6,  1'b1, 4'b0010, 2'd3, 12'h400, 4'b0000, 1'b0, 2'd0}  // R6 pre all
   };

   task automatic drive(input logic k, input logic [3:0] c,
                        input logic [1:0] b, input logic [11:0] a);
      @(negedge clk);
      cke = k;
      {cs_n, ras_n, cas_n, we_n} = c;
      ba = b;
      addr = a;
      @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check("R1 reset", {bank_open, bank_row, pwr_state, err_pulse}, '0);
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         logic [29:0] v;
         v = VEC[i];
         drive(v[25], v[24:21], v[20:19], v[18:7]);
         check($sformatf("R%0d vector %0d", v[29:26], i),
               {bank_open, err_pulse, pwr_state}, {v[6:3], v[2], v[1:0]});
      end

      // R3: row latched for the addressed bank
      drive(1'b1, 4'b0011, 2'd3, 12'hABC);
      check("R3 row bank3", bank_row[3*ROW_W +: ROW_W], 12'hABC);
      drive(1'b1, 4'b0011, 2'd1, 12'hFFF);
      check("R3 row bank1", bank_row[1*ROW_W +: ROW_W], 12'hFFF);
      // R5: second activate keeps the old row
      drive(1'b1, 4'b0011, 2'd3, 12'h111);
      check("R5 row kept", {bank_row[3*ROW_W +: ROW_W], err_pulse}, {12'hABC, 1'b1});
      drive(1'b1, 4'b0111, 2'd0, 12'h000);
      check("R4 err one cycle", err_pulse, 1'b0);
      // R2: deselected activate leaves row of idle bank 0 unchanged
      drive(1'b1, 4'b1011, 2'd0, 12'h777);
      check("R2 deselect row", {bank_open, bank_row[0 +: ROW_W]}, {4'b1010, 12'h040});
      // R1: mid-run reset clears everything
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      check("R1 mid reset", {bank_open, bank_row, pwr_state, err_pulse}, '0);
      @(negedge clk);
      rst = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule